// File: doc/BRIEF.md
# CORDIC-Mixed CIC Digital Downconverter

This block is one receive channel that shifts an intermediate-frequency sample stream down to baseband and then lowers its sample rate. Each accepted input sample is a complex pair. When only a real signal is present, the imaginary input is held at zero. A 32-bit phase accumulator advances by a tuning word once per accepted sample. Its upper bits steer a pipelined rotation-mode CORDIC. The CORDIC turns the input vector by minus the accumulated phase, using only shifts and additions.

The mixed I and Q streams each feed their own three-stage CIC decimator. Integrators run at the input rate and combs run at the output rate. The ratio can be set anywhere from 1 to 256. A small controller with two states, `ST_RELOAD` and `ST_RUN`, owns the decimation count. After reset it sits in `ST_RELOAD`. It always moves from `ST_RELOAD` to `ST_RUN` on the next clock. It returns from `ST_RUN` to `ST_RELOAD` whenever the requested ratio differs from the ratio it holds. While in `ST_RELOAD` it latches the new ratio, clears the sample counter and clears the comb delay registers. The integrators are left untouched.

For example, a 64 MS/s input with a ratio of 256 produces 250 kS/s of baseband I/Q.

Top module: `ddc_channel`

## Requirements
- R1: While reset is held and immediately after it, `out_valid` is 0 and both `out_i` and `out_q` are 0.
- R2: The phase advances by `freq_word` (modulo 2^32) once per accepted sample. The first sample after reset sees phase 0. The rotation angle is phase bits [31:16], where 65536 units make one full turn.
- R3: For a sample (x, y) at angle θ, the mixed values are I = K·(x·cosθ + y·sinθ) and Q = K·(y·cosθ − x·sinθ), with K ≈ 1.6468. Each result is within 6 LSB of the 14-bit mixer scale.
- R4: With the imaginary input at zero, I = K·x·cosθ and Q = −K·x·sinθ. This holds in all four quadrants, including angles of exactly 90°, 180° and 270°.
- R5: At ratio 1, every accepted sample produces exactly one output. That output equals the mixed sample, sign-extended to 38 bits, in input order.
- R6: `out_valid` pulses exactly once for every R accepted samples, with R the effective ratio. Samples left over that do not complete a block of R produce no pulse.
- R7: Once the comb history has filled after a ratio change, a constant mixed input C gives an output of exactly R^3·C.
- R8: The `decim_ratio` code maps as follows: 1 to 256 is taken as is, 0 acts as 1, and any value above 256 acts as 256. At ratio 256 with full-scale input, the output equals 2^24·C with no loss.
- R9: A change of ratio restarts the sample count. The first output under the new ratio follows exactly R_new accepted samples, however many samples had been counted before the change.
- R10: Cycles with `in_valid` low neither advance the phase nor count toward decimation. Gaps in the stream leave every result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks an accepted input sample |
| in_re | input | 12 | Real input sample, signed |
| in_im | input | 12 | Imaginary input sample, signed (tie to 0 for real-only input) |
| freq_word | input | 32 | Phase increment per accepted sample |
| decim_ratio | input | 9 | Requested decimation ratio (0 acts as 1, above 256 acts as 256) |
| out_valid | output | 1 | One-cycle strobe for a new baseband pair |
| out_i | output | 38 | Baseband in-phase output, signed |
| out_q | output | 38 | Baseband quadrature output, signed |

## Verification
The bench targets the angles where the quadrant fold applies: exactly 90°, 180° and 270°. A fold that triggers on the wrong half of the circle or subtracts the wrong half-turn flips the sign of I or Q, which a tolerance check catches at once. It changes the ratio while a partial block is pending. A counter that is not restarted would then emit its first new output too early. It feeds full-scale DC through ratio 256 and compares the result with an exact R^3 product. Too few guard bits, or a missing comb stage, breaks that equality. Gaps in `in_valid` expose a phase accumulator or counter that advances on idle cycles, because the expected angles and output counts are tied to the sample index.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    localparam int IN_W_DEF    = 12;
    localparam int PHASE_W_DEF = 32;
    localparam int ANGLE_W_DEF = 16;
    localparam int ITER_DEF    = 14;
    localparam int FRAC_W_DEF  = 4;
    localparam int STAGES_DEF  = 3;
    localparam int RMAX_DEF    = 256;

    typedef enum logic [0:0] {
        ST_RELOAD = 1'b0,
        ST_RUN    = 1'b1
    } dec_state_t;

    // arctan(2^-k) in units of 1/65536 turn; at most 14 iterations are meaningful
    function automatic logic [15:0] atan_step(input int k);
        logic [15:0] v;
        case (k)
            0:       v = 16'd8192;
            1:       v = 16'd4836;
            2:       v = 16'd2555;
            3:       v = 16'd1297;
            4:       v = 16'd651;
            5:       v = 16'd326;
            6:       v = 16'd163;
            7:       v = 16'd81;
            8:       v = 16'd41;
            9:       v = 16'd20;
            10:      v = 16'd10;
            11:      v = 16'd5;
            12:      v = 16'd3;
            13:      v = 16'd1;
            default: v = 16'd0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ddc_cordic.sv
module ddc_cordic #(
    parameter int IN_W    = ddc_pkg::IN_W_DEF,
    parameter int ANGLE_W = ddc_pkg::ANGLE_W_DEF,
    parameter int ITER    = ddc_pkg::ITER_DEF,
    parameter int FRAC_W  = ddc_pkg::FRAC_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic signed [IN_W-1:0]    in_x,
    input  logic signed [IN_W-1:0]    in_y,
    input  logic [ANGLE_W-1:0]        in_angle,
    output logic                      out_valid,
    output logic signed [IN_W+1:0]    out_x,
    output logic signed [IN_W+1:0]    out_y
);
    localparam int W  = IN_W + 2 + FRAC_W;
    localparam int ZW = ANGLE_W + 2;

    logic signed [W-1:0]  xs [ITER+1];
    logic signed [W-1:0]  ys [ITER+1];
    logic signed [ZW-1:0] zs [ITER+1];
    logic                 vs [ITER+1];

    logic [ANGLE_W-1:0]   neg_a;
    logic                 fold;
    logic [ANGLE_W-1:0]   z_fold;
    logic signed [W-1:0]  x_ext, y_ext;

    // rotate by minus the phase; fold [90,270) degrees by a half-turn
    always_comb begin
        neg_a  = -in_angle;
        fold   = neg_a[ANGLE_W-1] ^ neg_a[ANGLE_W-2];
        z_fold = {neg_a[ANGLE_W-1] ^ fold, neg_a[ANGLE_W-2:0]};
        x_ext  = {{2{in_x[IN_W-1]}}, in_x, {FRAC_W{1'b0}}};
        y_ext  = {{2{in_y[IN_W-1]}}, in_y, {FRAC_W{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s <= ITER; s++) begin
                xs[s] <= '0;
                ys[s] <= '0;
                zs[s] <= '0;
                vs[s] <= 1'b0;
            end
        end else begin
            vs[0] <= in_valid;
            xs[0] <= fold ? -x_ext : x_ext;
            ys[0] <= fold ? -y_ext : y_ext;
            zs[0] <= {{2{z_fold[ANGLE_W-1]}}, z_fold};
            for (int k = 0; k < ITER; k++) begin
                vs[k+1] <= vs[k];
                if (zs[k][ZW-1]) begin
                    xs[k+1] <= xs[k] + (ys[k] >>> k);
                    ys[k+1] <= ys[k] - (xs[k] >>> k);
                    zs[k+1] <= zs[k] + $signed({{(ZW-16){1'b0}}, ddc_pkg::atan_step(k)});
                end else begin
                    xs[k+1] <= xs[k] - (ys[k] >>> k);
                    ys[k+1] <= ys[k] + (xs[k] >>> k);
                    zs[k+1] <= zs[k] - $signed({{(ZW-16){1'b0}}, ddc_pkg::atan_step(k)});
                end
            end
        end
    end

    assign out_valid = vs[ITER];
    assign out_x     = xs[ITER][W-1:FRAC_W];
    assign out_y     = ys[ITER][W-1:FRAC_W];

endmodule

// File: rtl/ddc_decim_ctrl.sv
module ddc_decim_ctrl
    import ddc_pkg::*;
#(
    parameter int RMAX = ddc_pkg::RMAX_DEF,
    parameter int RW   = $clog2(RMAX) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ratio_req,
    input  logic          smp_valid,
    output logic          dump,
    output logic          reload,
    output logic          running,
    output logic [RW-1:0] ratio_held
);
    localparam int CNT_W = $clog2(RMAX);

    dec_state_t       state_q, state_d;
    logic [RW-1:0]    eff;
    logic [CNT_W-1:0] cnt_q;
    logic             last_slot;

    always_comb begin
        if (ratio_req == '0)
            eff = RW'(1);
        else if (ratio_req > RW'(RMAX))
            eff = RW'(RMAX);
        else
            eff = ratio_req;
    end

    assign last_slot = (cnt_q == CNT_W'(ratio_held - RW'(1)));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_RELOAD;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RELOAD: state_d = ST_RUN;
            ST_RUN:    if (eff != ratio_held) state_d = ST_RELOAD;
        endcase
    end

    // outputs
    always_comb begin
        dump    = 1'b0;
        reload  = 1'b0;
        running = 1'b0;
        unique case (state_q)
            ST_RELOAD: reload = 1'b1;
            ST_RUN: begin
                running = 1'b1;
                dump    = smp_valid && last_slot;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_held <= RW'(1);
            cnt_q      <= '0;
        end else if (reload) begin
            ratio_held <= eff;
            cnt_q      <= '0;
        end else if (smp_valid) begin
            cnt_q <= last_slot ? '0 : cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ddc_cic.sv
module ddc_cic #(
    parameter int IN_W   = ddc_pkg::IN_W_DEF + 2,
    parameter int STAGES = ddc_pkg::STAGES_DEF,
    parameter int GROWTH = ddc_pkg::STAGES_DEF * $clog2(ddc_pkg::RMAX_DEF),
    parameter int OW     = IN_W + GROWTH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic signed [IN_W-1:0] in_data,
    input  logic                  dump,
    input  logic                  clear,
    output logic                  out_valid,
    output logic signed [OW-1:0]  out_data
);
    logic signed [OW-1:0] integ [STAGES];
    logic signed [OW-1:0] sum   [STAGES];
    logic signed [OW-1:0] dly   [STAGES];
    logic signed [OW-1:0] dif   [STAGES];
    logic signed [OW-1:0] ext;

    always_comb begin
        ext    = {{GROWTH{in_data[IN_W-1]}}, in_data};
        sum[0] = integ[0] + ext;
        for (int k = 1; k < STAGES; k++)
            sum[k] = integ[k] + sum[k-1];
        dif[0] = sum[STAGES-1] - dly[0];
        for (int k = 1; k < STAGES; k++)
            dif[k] = dif[k-1] - dly[k];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                integ[k] <= '0;
                dly[k]   <= '0;
            end
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid)
                for (int k = 0; k < STAGES; k++)
                    integ[k] <= sum[k];
            if (clear) begin
                for (int k = 0; k < STAGES; k++)
                    dly[k] <= '0;
            end else if (dump) begin
                dly[0] <= sum[STAGES-1];
                for (int k = 1; k < STAGES; k++)
                    dly[k] <= dif[k-1];
                out_data  <= dif[STAGES-1];
                out_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ddc_channel.sv
module ddc_channel #(
    parameter int IN_W    = ddc_pkg::IN_W_DEF,
    parameter int PHASE_W = ddc_pkg::PHASE_W_DEF,
    parameter int ANGLE_W = ddc_pkg::ANGLE_W_DEF,
    parameter int ITER    = ddc_pkg::ITER_DEF,
    parameter int FRAC_W  = ddc_pkg::FRAC_W_DEF,
    parameter int STAGES  = ddc_pkg::STAGES_DEF,
    parameter int RMAX    = ddc_pkg::RMAX_DEF,
    parameter int RW      = $clog2(RMAX) + 1,
    parameter int MIX_W   = IN_W + 2,
    parameter int OUT_W   = MIX_W + STAGES * $clog2(RMAX)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_re,
    input  logic signed [IN_W-1:0]   in_im,
    input  logic [PHASE_W-1:0]       freq_word,
    input  logic [RW-1:0]            decim_ratio,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_i,
    output logic signed [OUT_W-1:0]  out_q
);
    logic [PHASE_W-1:0]       phase_q;
    logic                     mix_valid;
    logic signed [MIX_W-1:0]  mix_lane  [2];
    logic signed [OUT_W-1:0]  lane_out  [2];
    logic                     lane_valid [2];
    logic                     dump, reload, running;
    logic [RW-1:0]            ratio_held;

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (in_valid)
            phase_q <= phase_q + freq_word;
    end

    ddc_cordic #(
        .IN_W(IN_W), .ANGLE_W(ANGLE_W), .ITER(ITER), .FRAC_W(FRAC_W)
    ) u_cordic (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_x      (in_re),
        .in_y      (in_im),
        .in_angle  (phase_q[PHASE_W-1 -: ANGLE_W]),
        .out_valid (mix_valid),
        .out_x     (mix_lane[0]),
        .out_y     (mix_lane[1])
    );

    ddc_decim_ctrl #(.RMAX(RMAX), .RW(RW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_req  (decim_ratio),
        .smp_valid  (mix_valid),
        .dump       (dump),
        .reload     (reload),
        .running    (running),
        .ratio_held (ratio_held)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        ddc_cic #(
            .IN_W(MIX_W), .STAGES(STAGES), .GROWTH(OUT_W - MIX_W), .OW(OUT_W)
        ) u_cic (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (mix_valid),
            .in_data   (mix_lane[g]),
            .dump      (dump),
            .clear     (reload),
            .out_valid (lane_valid[g]),
            .out_data  (lane_out[g])
        );
    end

    assign out_valid = lane_valid[0];
    assign out_i     = lane_out[0];
    assign out_q     = lane_out[1];

endmodule

// File: rtl/ddc_channel_checker.sv
module ddc_channel_checker #(
    parameter int PHASE_W = 32,
    parameter int RW      = 9,
    parameter int RMAX    = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [PHASE_W-1:0] freq_word,
    input  logic [PHASE_W-1:0] phase_q,
    input  logic               mix_valid,
    input  logic               running,
    input  logic               reload,
    input  logic [RW-1:0]      ratio_held,
    input  logic               valid_i,
    input  logic               valid_q
);
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> phase_q == $past(phase_q + freq_word));

    assert_phase_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(phase_q));

    assert_lanes_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i == valid_q);

    assert_out_needs_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> $past(mix_valid));

    assert_no_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ratio_held > RW'(1)) |=> !valid_i);

    assert_unit_ratio_each_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ratio_held == RW'(1) && mix_valid) |=> valid_i);

    assert_reload_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !valid_i);

    assert_ratio_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_held >= RW'(1) && ratio_held <= RW'(RMAX));

endmodule

bind ddc_channel ddc_channel_checker #(
    .PHASE_W(PHASE_W), .RW(RW), .RMAX(RMAX)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .freq_word  (freq_word),
    .phase_q    (phase_q),
    .mix_valid  (mix_valid),
    .running    (running),
    .reload     (reload),
    .ratio_held (ratio_held),
    .valid_i    (lane_valid[0]),
    .valid_q    (lane_valid[1])
);

// File: tb/ddc_channel_bench.sv
`timescale 1ns/1ps
module ddc_channel_bench;
    localparam real KG  = 1.6467602;
    localparam real TOL = 6.0;
    localparam real PI2 = 6.283185307179586;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [11:0] in_re = '0;
    logic signed [11:0] in_im = '0;
    logic [31:0]        freq_word = '0;
    logic [8:0]         decim_ratio = 9'd1;
    logic               out_valid;
    logic signed [37:0] out_i, out_q;

    int     n_tests = 0;
    int     n_fail  = 0;
    longint cap_i [2048];
    longint cap_q [2048];
    int     ncap = 0;

    always #4 clk = ~clk;

    ddc_channel u_ddc_channel (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .freq_word(freq_word), .decim_ratio(decim_ratio),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && ncap < 2048) begin
            cap_i[ncap] = longint'(out_i);
            cap_q[ncap] = longint'(out_q);
            ncap++;
        end
    end

    function automatic real exp_i(int x, int y, int ang);
        real th;
        th = PI2 * ang / 65536.0;
        return KG * (x * $cos(th) + y * $sin(th));
    endfunction

    function automatic real exp_q(int x, int y, int ang);
        real th;
        th = PI2 * ang / 65536.0;
        return KG * (y * $cos(th) - x * $sin(th));
    endfunction

    task automatic chk_eq(string tag, longint act, longint expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic chk_near(string tag, longint act, real expv);
        real d;
        n_tests++;
        d = act - expv;
        if (d < 0.0) d = -d;
        if (d > TOL) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0.2f", tag, act, expv);
        end
    endtask

    task automatic do_reset(input logic [8:0] ratio, input logic [31:0] fw);
        in_valid    = 1'b0;
        decim_ratio = ratio;
        freq_word   = fw;
        rst_n       = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ncap  = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic put(input int x, input int y);
        in_re    = 12'(x);
        in_im    = 12'(y);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (24) @(negedge clk);
    endtask

    task automatic set_ratio(input logic [8:0] r);
        decim_ratio = r;
        repeat (4) @(negedge clk);
        ncap = 0;
    endtask

    // R1: quiet outputs after reset
    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        chk_eq("R1 valid in reset", longint'(out_valid), 0);
        do_reset(9'd1, 32'd0);
        chk_eq("R1 valid", longint'(out_valid), 0);
        chk_eq("R1 out_i", longint'(out_i), 0);
        chk_eq("R1 out_q", longint'(out_q), 0);
    endtask

    // R5, R3: zero tuning, ratio 1, one output per sample
    task automatic t_passthrough();
        int xs [8] = '{0, 1000, -1000, 2047, -2048, 37, 1500, -700};
        int ys [8] = '{0, -500, 2047, 0, -2048, -1900, 1500, 333};
        do_reset(9'd1, 32'd0);
        for (int k = 0; k < 8; k++) put(xs[k], ys[k]);
        drain();
        chk_eq("R5 output count", ncap, 8);
        for (int k = 0; k < 8; k++) begin
            chk_near("R3 dc I", cap_i[k], exp_i(xs[k], ys[k], 0));
            chk_near("R3 dc Q", cap_q[k], exp_q(xs[k], ys[k], 0));
        end
    endtask

    // R2, R3, R10: rotating phase, gaps in the stream
    task automatic t_rotating();
        logic [31:0] ph;
        int xs [24];
        int ys [24];
        int angs [24];
        do_reset(9'd1, 32'h1357_9BDF);
        ph = '0;
        for (int k = 0; k < 24; k++) begin
            xs[k]   = (k * 397) % 4000 - 2000;
            ys[k]   = (k * 733) % 3900 - 1950;
            angs[k] = int'(ph[31:16]);
            ph      = ph + 32'h1357_9BDF;
            put(xs[k], ys[k]);
            if (k % 2 == 1) repeat (2) @(negedge clk);
        end
        drain();
        chk_eq("R10 output count with gaps", ncap, 24);
        for (int k = 0; k < 24; k++) begin
            chk_near("R2 rotate I", cap_i[k], exp_i(xs[k], ys[k], angs[k]));
            chk_near("R3 rotate Q", cap_q[k], exp_q(xs[k], ys[k], angs[k]));
        end
    endtask

    // R4: real-only input at quarter-turn steps
    task automatic t_real_only();
        do_reset(9'd1, 32'h4000_0000);
        for (int k = 0; k < 8; k++) put(1800 - k * 300, 0);
        drain();
        chk_eq("R4 output count", ncap, 8);
        for (int k = 0; k < 8; k++) begin
            chk_near("R4 real I", cap_i[k], exp_i(1800 - k * 300, 0, (k % 4) * 16384));
            chk_near("R4 real Q", cap_q[k], exp_q(1800 - k * 300, 0, (k % 4) * 16384));
        end
    endtask

    // R6, R10: cadence with gaps and a partial tail
    task automatic t_cadence();
        do_reset(9'd5, 32'd0);
        for (int k = 0; k < 53; k++) begin
            put(100, 50);
            if (k % 3 == 0) @(negedge clk);
        end
        drain();
        chk_eq("R6 outputs for 53 samples at R=5", ncap, 10);
    endtask

    // R7: DC gain R^3 at ratio 4
    task automatic t_dc_gain();
        longint ci, cq;
        do_reset(9'd1, 32'd0);
        put(300, -100);
        drain();
        ci = cap_i[0];
        cq = cap_q[0];
        chk_near("R3 reference I", ci, exp_i(300, -100, 0));
        set_ratio(9'd4);
        for (int k = 0; k < 32; k++) put(300, -100);
        drain();
        chk_eq("R6 outputs at R=4", ncap, 8);
        chk_eq("R7 gain I", cap_i[7], ci * 64);
        chk_eq("R7 gain Q", cap_q[7], cq * 64);
    endtask

    // R8: ratio code clamping and full-scale growth
    task automatic t_clamp();
        longint ci;
        do_reset(9'd0, 32'd0);
        for (int k = 0; k < 6; k++) put(10 * k, 0);
        drain();
        chk_eq("R8 ratio 0 acts as 1", ncap, 6);
        do_reset(9'd1, 32'd0);
        put(-2048, 0);
        drain();
        ci = cap_i[0];
        set_ratio(9'd300);
        for (int k = 0; k < 256 * 5; k++) put(-2048, 0);
        drain();
        chk_eq("R8 ratio 300 acts as 256", ncap, 5);
        chk_eq("R8 full scale gain", cap_i[4], ci * 64'sd16777216);
    endtask

    // R9: ratio change restarts the count
    task automatic t_change();
        do_reset(9'd3, 32'd0);
        for (int k = 0; k < 7; k++) put(20, 20);
        drain();
        chk_eq("R9 outputs before change", ncap, 2);
        set_ratio(9'd4);
        for (int k = 0; k < 3; k++) put(20, 20);
        drain();
        chk_eq("R9 no early output", ncap, 0);
        put(20, 20);
        drain();
        chk_eq("R9 output after R_new samples", ncap, 1);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_passthrough();
        t_rotating();
        t_real_only();
        t_cadence();
        t_dc_gain();
        t_clamp();
        t_change();
        report();
        $finish;
    end

endmodule